// File: doc/BRIEF.md
# Stereo Half-dB Volume Stage with Soft Mute

This block scales a stereo pair of signed PCM samples by a programmable attenuation. Each side has its own 8-bit gain code in half-decibel steps. The range runs from a boost of about +24 dB down to −63.5 dB, and the codes above that range silence the channel. A shared soft-mute request moves both channels toward silence one half-decibel step per sample. Releasing the request moves them back to the programmed level at the same rate. An automatic-gain-control enable takes the whole stage out of the path, so samples pass through unchanged.

The gain is not computed as a full exponential. The attenuation, counted in half-decibel steps, is split into a position inside a six-decibel octave and a number of octaves. The position selects one of twelve fractional multipliers. The octave count becomes an arithmetic right shift. A fixed left shift of four bits provides the positive gains. Results saturate to the sample range.

The block updates its outputs once per sample strobe. The parent logic may write gain codes, the mute request and the bypass at any time. They act only at the next strobe.

Top module: `vol_stereo_top`

## Requirements
- R1: For a gain code c from 0 to 175, the attenuation a equals c plus the mute ramp position. The output is floor(x·T[a mod 12] / 2^(11 + a div 12)), where x is the input sample and T[k] = round(32768·10^(−k/40)). This gives 24 − 0.5·c dB when the ramp is at 0.
- R2: A lane whose attenuation c plus the ramp position is 176 or more outputs exactly 0. This covers gain codes 176 to 255 at any ramp position.
- R3: Every scaled result is clamped to the signed 16-bit range [−32768, 32767] and never wraps.
- R4: Outputs and mute_done change only on the clock edge where smp_stb is high. That edge uses the samples, gain codes, mute request and bypass present at that edge. Input changes between strobes have no effect until the next strobe.
- R5: While agc_bypass is high at a strobe, each output equals its input sample exactly, whatever the gain code or mute state.
- R6: At each strobe where mute_req is high and the ramp position is below 256, the ramp position rises by one 0.5 dB step. The output computed at that strobe uses the position held before the strobe.
- R7: mute_done is high exactly when the ramp position is 256. Any non-bypassed strobe taken while mute_done is high outputs 0.
- R8: At each strobe where mute_req is low and the ramp position is above 0, the ramp position falls by one. mute_done therefore drops after the first such strobe.
- R9: Synchronous active-high reset clears both outputs to 0, the ramp position to 0 and mute_done to 0.
- R10: The ramp position keeps following mute_req while agc_bypass is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle sample strobe |
| smp_l | input | 16 | Left input sample, signed |
| smp_r | input | 16 | Right input sample, signed |
| gain_l | input | 8 | Left gain code, 0.5 dB per step, 0 = +24 dB |
| gain_r | input | 8 | Right gain code |
| mute_req | input | 1 | Soft-mute request, level sensitive |
| agc_bypass | input | 1 | Pass samples straight through |
| out_l | output | 16 | Left scaled sample, signed |
| out_r | output | 16 | Right scaled sample, signed |
| mute_done | output | 1 | Ramp has reached silence |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 8-bit codes and a 256-step ramp. At these values every gain code, including all the mute codes, can be swept against a set of signed samples that reach both rails, so the boost and the clamp are both exercised. A full 256-step descent and the complete climb back can also be driven one strobe at a time. A mid-ramp release and bypass during a ramp are covered as well. The expected outputs come from the requirement formula, evaluated in real arithmetic in the bench.

// File: rtl/vol_pkg.sv
package vol_pkg;

    localparam int FRAC_W     = 16;
    localparam int FRAC_STEPS = 12;
    localparam int FRAC_SH    = 15;
    localparam int IDX_W      = 4;
    localparam int SH_W       = 5;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_DOWN = 2'd1,
        RAMP_UP   = 2'd2
    } ramp_dir_t;

    typedef struct packed {
        logic             silent;
        logic [IDX_W-1:0] idx;
        logic [SH_W-1:0]  octave;
    } gain_sel_t;

    // Multipliers 10^(-k/40) in Q15 for half-dB positions inside one octave.
    function automatic logic [FRAC_W-1:0] frac_mult(input logic [IDX_W-1:0] k);
        logic [FRAC_W-1:0] m;
        case (k)
            4'd0:    m = 16'd32768;
            4'd1:    m = 16'd30935;
            4'd2:    m = 16'd29205;
            4'd3:    m = 16'd27571;
            4'd4:    m = 16'd26029;
            4'd5:    m = 16'd24573;
            4'd6:    m = 16'd23198;
            4'd7:    m = 16'd21900;
            4'd8:    m = 16'd20675;
            4'd9:    m = 16'd19519;
            4'd10:   m = 16'd18427;
            4'd11:   m = 16'd17396;
            default: m = 16'd0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vol_ramp.sv
module vol_ramp
    import vol_pkg::*;
#(
    parameter int RAMP_STEPS = 256,
    localparam int RAMP_W    = $clog2(RAMP_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              mute_req,
    output logic [RAMP_W-1:0] pos,
    output logic              done
);

    localparam logic [RAMP_W-1:0] TOP = RAMP_W'(RAMP_STEPS);

    ramp_dir_t dir;

    always_comb begin
        if (mute_req && pos != TOP)
            dir = RAMP_UP;
        else if (!mute_req && pos != '0)
            dir = RAMP_DOWN;
        else
            dir = RAMP_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (stb) begin
            case (dir)
                RAMP_UP:   pos <= pos + 1'b1;
                RAMP_DOWN: pos <= pos - 1'b1;
                default:   pos <= pos;
            endcase
        end
    end

    assign done = (pos == TOP);

endmodule

// File: rtl/vol_lane.sv
module vol_lane
    import vol_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CODE_W    = 8,
    parameter int RAMP_W    = 9,
    parameter int MUTE_CODE = 176,
    parameter int BOOST_SH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              bypass,
    input  logic [DATA_W-1:0] x,
    input  logic [CODE_W-1:0] code,
    input  logic [RAMP_W-1:0] ramp,
    output logic [DATA_W-1:0] y
);

    localparam int ATT_W  = ((CODE_W > RAMP_W) ? CODE_W : RAMP_W) + 1;
    localparam int PROD_W = DATA_W + FRAC_W + 1;
    localparam int BASE_SH = FRAC_SH - BOOST_SH;
    localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((64'sd1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] MINV = -MAXV - 1;

    logic [ATT_W-1:0]         att;
    gain_sel_t                sel;
    logic [FRAC_W-1:0]        mult;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic [DATA_W-1:0]        nxt;

    always_comb begin
        att        = ATT_W'(code) + ATT_W'(ramp);
        sel.silent = (att >= ATT_W'(MUTE_CODE));
        sel.idx    = IDX_W'(att % ATT_W'(FRAC_STEPS));
        sel.octave = SH_W'(att / ATT_W'(FRAC_STEPS));
    end

    always_comb begin
        mult   = frac_mult(sel.idx);
        prod   = $signed({{(FRAC_W + 1){x[DATA_W-1]}}, x})
               * $signed({{DATA_W{1'b0}}, 1'b0, mult});
        scaled = prod >>> (BASE_SH + int'(sel.octave));
        if (bypass)
            nxt = x;
        else if (sel.silent)
            nxt = '0;
        else if (scaled > MAXV)
            nxt = MAXV[DATA_W-1:0];
        else if (scaled < MINV)
            nxt = MINV[DATA_W-1:0];
        else
            nxt = scaled[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            y <= '0;
        else if (stb)
            y <= nxt;
    end

endmodule

// File: rtl/vol_stereo_top.sv
module vol_stereo_top #(
    parameter int DATA_W     = 16,
    parameter int CODE_W     = 8,
    parameter int RAMP_STEPS = 256,
    parameter int MUTE_CODE  = 176,
    parameter int BOOST_SH   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] smp_l,
    input  logic [DATA_W-1:0] smp_r,
    input  logic [CODE_W-1:0] gain_l,
    input  logic [CODE_W-1:0] gain_r,
    input  logic              mute_req,
    input  logic              agc_bypass,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r,
    output logic              mute_done
);

    localparam int LANES  = 2;
    localparam int RAMP_W = $clog2(RAMP_STEPS + 1);

    logic [RAMP_W-1:0] ramp_pos;
    logic [DATA_W-1:0] lane_x [LANES];
    logic [CODE_W-1:0] lane_c [LANES];
    logic [DATA_W-1:0] lane_y [LANES];

    assign lane_x[0] = smp_l;
    assign lane_x[1] = smp_r;
    assign lane_c[0] = gain_l;
    assign lane_c[1] = gain_r;
    assign out_l     = lane_y[0];
    assign out_r     = lane_y[1];

    vol_ramp #(
        .RAMP_STEPS (RAMP_STEPS)
    ) u_ramp (
        .clk      (clk),
        .rst      (rst),
        .stb      (smp_stb),
        .mute_req (mute_req),
        .pos      (ramp_pos),
        .done     (mute_done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vol_lane #(
            .DATA_W    (DATA_W),
            .CODE_W    (CODE_W),
            .RAMP_W    (RAMP_W),
            .MUTE_CODE (MUTE_CODE),
            .BOOST_SH  (BOOST_SH)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .stb    (smp_stb),
            .bypass (agc_bypass),
            .x      (lane_x[g]),
            .code   (lane_c[g]),
            .ramp   (ramp_pos),
            .y      (lane_y[g])
        );
    end

endmodule

// File: rtl/vol_stereo_chk.sv
module vol_stereo_chk #(
    parameter int DATA_W    = 16,
    parameter int CODE_W    = 8,
    parameter int MUTE_CODE = 176
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_stb,
    input logic [DATA_W-1:0] smp_l,
    input logic [DATA_W-1:0] smp_r,
    input logic [CODE_W-1:0] gain_l,
    input logic [CODE_W-1:0] gain_r,
    input logic              mute_req,
    input logic              agc_bypass,
    input logic [DATA_W-1:0] out_l,
    input logic [DATA_W-1:0] out_r,
    input logic              mute_done
);

    // R4
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> ($stable(out_l) && $stable(out_r) && $stable(mute_done)));

    // R2
    mute_code_zero_l_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !agc_bypass && gain_l >= CODE_W'(MUTE_CODE)) |=> (out_l == '0));

    // R2
    mute_code_zero_r_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !agc_bypass && gain_r >= CODE_W'(MUTE_CODE)) |=> (out_r == '0));

    // R5
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && agc_bypass) |=> (out_l == $past(smp_l) && out_r == $past(smp_r)));

    // R7
    silent_when_done_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && mute_done && !agc_bypass) |=> (out_l == '0 && out_r == '0));

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mute_done) |-> $past(smp_stb && mute_req));

    // R8
    done_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mute_done) |-> $past(smp_stb && !mute_req));

endmodule

bind vol_stereo_top vol_stereo_chk #(
    .DATA_W    (DATA_W),
    .CODE_W    (CODE_W),
    .MUTE_CODE (MUTE_CODE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_stb    (smp_stb),
    .smp_l      (smp_l),
    .smp_r      (smp_r),
    .gain_l     (gain_l),
    .gain_r     (gain_r),
    .mute_req   (mute_req),
    .agc_bypass (agc_bypass),
    .out_l      (out_l),
    .out_r      (out_r),
    .mute_done  (mute_done)
);

// File: tb/sim_vol_stereo_top.sv
module sim_vol_stereo_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic [15:0] smp_l = '0;
    logic [15:0] smp_r = '0;
    logic [7:0]  gain_l = '0;
    logic [7:0]  gain_r = '0;
    logic        mute_req = 1'b0;
    logic        agc_bypass = 1'b0;
    logic [15:0] out_l;
    logic [15:0] out_r;
    logic        mute_done;

    int checks = 0;
    int errors = 0;
    int ramp_m = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vol_stereo_top u0 (
        .clk        (clk),
        .rst        (rst),
        .smp_stb    (smp_stb),
        .smp_l      (smp_l),
        .smp_r      (smp_r),
        .gain_l     (gain_l),
        .gain_r     (gain_r),
        .mute_req   (mute_req),
        .agc_bypass (agc_bypass),
        .out_l      (out_l),
        .out_r      (out_r),
        .mute_done  (mute_done)
    );

    function automatic int unclamped(int x, int att);
        longint tab;
        longint p;
        tab = longint'($rtoi($pow(10.0, -(att % 12) / 40.0) * 32768.0 + 0.5));
        p   = longint'(x) * tab;
        p   = p >>> (11 + att / 12);
        if (p > 40000) p = 40000;
        if (p < -40000) p = -40000;
        return int'(p);
    endfunction

    function automatic int model(int x, int code, int ramp, bit byp);
        int att;
        int v;
        if (byp) return x;
        att = code + ramp;
        if (att >= 176) return 0;
        v = unclamped(x, att);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic string tag_for(int x, int code, int ramp, bit byp);
        int att;
        int v;
        if (byp) return "R5";
        att = code + ramp;
        if (att >= 176) return "R2";
        v = unclamped(x, att);
        if (v > 32767 || v < -32768) return "R3";
        return "R1";
    endfunction

    function automatic int sample_of(int k);
        case (k % 10)
            0: return 0;
            1: return 1;
            2: return -1;
            3: return 32767;
            4: return -32768;
            5: return 12345;
            6: return -20000;
            7: return 777;
            8: return -3;
            default: return 2049;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One strobe: drive at a falling edge, check at the next falling edge.
    task automatic strobe(int xl, int xr, int cl, int cr, bit mute, bit byp, string extra);
        int el;
        int er;
        string tl;
        string tr;
        @(negedge clk);
        smp_l = 16'(xl); smp_r = 16'(xr);
        gain_l = 8'(cl); gain_r = 8'(cr);
        mute_req = mute; agc_bypass = byp;
        smp_stb = 1'b1;
        el = model(xl, cl, ramp_m, byp);
        er = model(xr, cr, ramp_m, byp);
        tl = tag_for(xl, cl, ramp_m, byp);
        tr = tag_for(xr, cr, ramp_m, byp);
        if (mute && ramp_m < 256) ramp_m++;
        else if (!mute && ramp_m > 0) ramp_m--;
        @(negedge clk);
        smp_stb = 1'b0;
        check({tl, " left ", extra}, int'($signed(out_l)), el);
        check({tr, " right ", extra}, int'($signed(out_r)), er);
        check("R7 mute_done", int'(mute_done), (ramp_m == 256) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hl;
        int hr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check("R9 out_l", int'(out_l), 0);
        check("R9 out_r", int'(out_r), 0);
        check("R9 mute_done", int'(mute_done), 0);

        // R1 R2 R3: every code on both lanes against a set of samples
        for (int c = 0; c < 256; c++) begin
            for (int k = 0; k < 10; k++) begin
                strobe(sample_of(k), sample_of(k + 3), c, 255 - c, 1'b0, 1'b0, "sweep");
            end
        end

        // R4: input changes without a strobe leave the outputs alone
        strobe(10000, -10000, 2, 40, 1'b0, 1'b0, "R4 setup");
        hl = int'($signed(out_l));
        hr = int'($signed(out_r));
        @(negedge clk);
        smp_l = 16'd5; smp_r = 16'd9; gain_l = 8'd200; gain_r = 8'd0;
        agc_bypass = 1'b1; mute_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 hold left", int'($signed(out_l)), hl);
        check("R4 hold right", int'($signed(out_r)), hr);
        check("R4 hold done", int'(mute_done), 0);
        strobe(-7000, 7000, 30, 31, 1'b0, 1'b0, "R4 next strobe");

        // R5: bypass ignores gain code
        strobe(-32768, 32767, 255, 0, 1'b0, 1'b1, "R5 bypass");
        strobe(1234, -4321, 100, 200, 1'b0, 1'b1, "R5 bypass");

        // R6 R7: full descent from code 20
        for (int s = 0; s < 260; s++)
            strobe(20000, -15000, 20, 60, 1'b1, 1'b0, "R6 ramp down");
        check("R7 done after descent", int'(mute_done), 1);

        // R8: climb back, done drops on the first step up
        strobe(20000, -15000, 20, 60, 1'b0, 1'b0, "R8 first release");
        check("R8 done cleared", int'(mute_done), 0);
        for (int s = 0; s < 258; s++)
            strobe(20000, -15000, 20, 60, 1'b0, 1'b0, "R8 ramp up");

        // R6 R8: release part way down
        for (int s = 0; s < 30; s++)
            strobe(-30000, 30000, 0, 10, 1'b1, 1'b0, "R6 partial");
        for (int s = 0; s < 32; s++)
            strobe(-30000, 30000, 0, 10, 1'b0, 1'b0, "R8 partial");

        // R10 R5: ramp advances under bypass, visible once bypass drops
        for (int s = 0; s < 5; s++)
            strobe(3000, -3000, 4, 4, 1'b1, 1'b1, "R10 bypass ramp");
        strobe(3000, -3000, 4, 4, 1'b1, 1'b0, "R10 after bypass");
        for (int s = 0; s < 7; s++)
            strobe(3000, -3000, 4, 4, 1'b0, 1'b0, "R10 recover");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule